// File: doc/BRIEF.md
# Reconfigurable Ring Router for an Eight-Stage Lookup Cascade

This block is the switch fabric that joins eight lookup-table stages into cascades. Every stage takes a rail input. That rail is either the data output of the stage's horizontal neighbour or the data output of its vertical neighbour. The choice of neighbour, made per stage, lets the eight stages form one ring of eight, two rings of four, or four rings of two.

Inside each ring, one stage is marked as the head. The head's rail comes from an external I/O group instead of a neighbour. The ring's result is the data output of the stage that feeds the head. Four I/O groups register the external inputs and the ring results on the block clock.

The routing is set by static configuration registers, loaded through a write strobe. A write that does not describe well-formed rings raises an error flag and is not applied, so the routing that was in force stays in place. The stages themselves sit outside this block. Their data outputs arrive on `stage_dout` and their rails leave on `stage_rail`.

Top module: `lutring_xbar`

## Requirements
- R1: During and after reset the fabric is one ring of eight with stage 0 as head. `cfg_err` is low and every `ext_out` group reads zero.
- R2: Topology code 2'b00 (one ring) feeds each non-head stage s from stage (s+7) mod 8.
- R3: Topology code 2'b01 (two rings) forms ring 0 as 7→0→1→6→7 and ring 1 as 5→2→3→4→5. Each arrow points from the feeding stage to the fed stage.
- R4: Topology code 2'b10 (four rings) pairs stages (0,7), (1,6), (2,5) and (3,4), each stage feeding the other. The pair's ring number is its smaller stage index.
- R5: Bit s of `cfg_first` marks stage s as a head. A head's rail is the registered `ext_in` of the group whose index equals the head's ring number.
- R6: Each `ext_out` group g is updated on every clock edge:
  - When ring g exists, it takes the data output of the stage feeding ring g's head.
  - When ring g does not exist, it is zero.
- R7: A write with topology code 2'b11, or one in which any ring has a number of heads other than one, sets `cfg_err`. It leaves the routing and ring outputs unchanged.
- R8: A valid write clears `cfg_err`. The new routing takes effect on the rails in the cycle after the write edge.
- R9: An `ext_in` value reaches a head rail exactly one clock edge after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_topo | input | 2 | Topology code: 00 one ring, 01 two rings, 10 four rings, 11 illegal |
| cfg_first | input | 8 | Head-stage mask, bit s for stage s |
| ext_in | input | 4x8 | External inputs, one byte per I/O group |
| ext_out | output | 4x8 | Registered ring results, one byte per I/O group |
| stage_dout | input | 8x8 | Data outputs of the eight stages |
| stage_rail | output | 8x8 | Rail inputs delivered to the eight stages |
| cfg_err | output | 1 | High after a rejected configuration write |

## Verification
The assertions assume three things about the inputs:
- Configuration changes only through `cfg_we`.
- `cfg_topo` and `cfg_first` are sampled only on a strobe edge.
- `stage_dout` is an independent input rather than a function of the rails.

The stimulus honours this. It drives every input on the falling edge and gives each stage a fixed, distinct data byte, so no combinational path loops through the bench. Rejected writes always follow a valid one, so the bench can check that the earlier routing survives.

// File: rtl/lutring_pkg.sv
package lutring_pkg;
  localparam int unsigned NSTG = 8;
  localparam int unsigned NGRP = 4;

  typedef enum logic [1:0] {
    TOPO_RING8 = 2'b00,
    TOPO_RING4 = 2'b01,
    TOPO_RING2 = 2'b10,
    TOPO_BAD   = 2'b11
  } topo_e;

  // ring number a stage belongs to
  function automatic logic [1:0] loop_of(topo_e t, int unsigned s);
    case (t)
      TOPO_RING4: return (s == 0 || s == 1 || s == 6 || s == 7) ? 2'd0 : 2'd1;
      TOPO_RING2: return (s < 4) ? 2'(s) : 2'(7 - s);
      default:    return 2'd0;
    endcase
  endfunction

  // true when the stage takes its vertical neighbour
  function automatic logic use_vert(topo_e t, int unsigned s);
    case (t)
      TOPO_RING4: return (s == 2 || s == 6);
      TOPO_RING2: return (s != 0 && s != 4);
      default:    return 1'b0;
    endcase
  endfunction

  function automatic logic [2:0] src_of(topo_e t, int unsigned s);
    return use_vert(t, s) ? 3'(7 - s) : 3'((s + 7) % 8);
  endfunction

  function automatic int unsigned loop_count(topo_e t);
    case (t)
      TOPO_RING8: return 1;
      TOPO_RING4: return 2;
      TOPO_RING2: return 4;
      default:    return 0;
    endcase
  endfunction
endpackage

// File: rtl/lutring_cfg.sv
module lutring_cfg
  import lutring_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [1:0]      topo_in,
  input  logic [NSTG-1:0] first_in,
  output topo_e           act_topo,
  output logic [NSTG-1:0] act_first,
  output logic            cfg_err
);
  topo_e      wr_topo;
  logic [3:0] hits [NGRP];
  logic       wr_ok;

  assign wr_topo = topo_e'(topo_in);

  always_comb begin
    for (int unsigned g = 0; g < NGRP; g++) hits[g] = 4'd0;
    for (int unsigned s = 0; s < NSTG; s++)
      if (first_in[s]) hits[loop_of(wr_topo, s)] = hits[loop_of(wr_topo, s)] + 4'd1;
    wr_ok = (wr_topo != TOPO_BAD);
    for (int unsigned g = 0; g < NGRP; g++)
      if (g < loop_count(wr_topo) && hits[g] != 4'd1) wr_ok = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_topo  <= TOPO_RING8;
      act_first <= NSTG'(1);
      cfg_err   <= 1'b0;
    end else if (cfg_we) begin
      cfg_err <= !wr_ok;
      if (wr_ok) begin
        act_topo  <= wr_topo;
        act_first <= first_in;
      end
    end
  end

  AST_TOPO_LEGAL: assert property (@(posedge clk) disable iff (rst)
    act_topo != TOPO_BAD); // R7
  AST_HOLD_WHILE_ERR: assert property (@(posedge clk) disable iff (rst)
    (cfg_err && !cfg_we) |=> ($stable(act_topo) && $stable(act_first))); // R7
  AST_ERR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_err) |-> $past(cfg_we)); // R7
endmodule

// File: rtl/lutring_route.sv
module lutring_route
  import lutring_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  topo_e                 act_topo,
  input  logic [NSTG-1:0]       act_first,
  input  logic [NSTG-1:0][W-1:0] stage_dout,
  input  logic [NGRP-1:0][W-1:0] grp_in,
  output logic [NSTG-1:0][W-1:0] stage_rail,
  output logic [NGRP-1:0][W-1:0] last_dout,
  output logic [NGRP-1:0]       grp_used
);
  for (genvar s = 0; s < NSTG; s++) begin : g_rail
    always_comb begin
      if (act_first[s]) stage_rail[s] = grp_in[loop_of(act_topo, s)];
      else              stage_rail[s] = stage_dout[src_of(act_topo, s)];
    end
  end

  always_comb begin
    for (int unsigned g = 0; g < NGRP; g++) last_dout[g] = '0;
    for (int unsigned s = 0; s < NSTG; s++)
      if (act_first[s]) last_dout[loop_of(act_topo, s)] = stage_dout[src_of(act_topo, s)];
  end

  always_comb
    for (int unsigned g = 0; g < NGRP; g++) grp_used[g] = (g < loop_count(act_topo));

  AST_ONE_HEAD_PER_RING: assert property (@(posedge clk) disable iff (rst)
    $countones(act_first) == int'(loop_count(act_topo))); // R5
endmodule

// File: rtl/lutring_iogrp.sv
module lutring_iogrp #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ext_in,
  input  logic         used,
  input  logic [W-1:0] last_dout,
  output logic [W-1:0] in_q,
  output logic [W-1:0] out_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      in_q  <= '0;
      out_q <= '0;
    end else begin
      in_q  <= ext_in;
      out_q <= used ? last_dout : '0;
    end
  end

  AST_UNUSED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !used |=> (out_q == '0)); // R6
endmodule

// File: rtl/lutring_xbar.sv
module lutring_xbar
  import lutring_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_we,
  input  logic [1:0]             cfg_topo,
  input  logic [NSTG-1:0]        cfg_first,
  input  logic [NGRP-1:0][W-1:0] ext_in,
  output logic [NGRP-1:0][W-1:0] ext_out,
  input  logic [NSTG-1:0][W-1:0] stage_dout,
  output logic [NSTG-1:0][W-1:0] stage_rail,
  output logic                   cfg_err
);
  topo_e                  act_topo;
  logic [NSTG-1:0]        act_first;
  logic [NGRP-1:0][W-1:0] grp_in;
  logic [NGRP-1:0][W-1:0] last_dout;
  logic [NGRP-1:0]        grp_used;

  lutring_cfg u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .topo_in(cfg_topo), .first_in(cfg_first),
    .act_topo(act_topo), .act_first(act_first), .cfg_err(cfg_err)
  );

  lutring_route #(.W(W)) u_route (
    .clk(clk), .rst(rst), .act_topo(act_topo), .act_first(act_first),
    .stage_dout(stage_dout), .grp_in(grp_in), .stage_rail(stage_rail),
    .last_dout(last_dout), .grp_used(grp_used)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_io
    lutring_iogrp #(.W(W)) u_io (
      .clk(clk), .rst(rst), .ext_in(ext_in[g]), .used(grp_used[g]),
      .last_dout(last_dout[g]), .in_q(grp_in[g]), .out_q(ext_out[g])
    );
  end

  AST_HEAD_TAKES_INPUT: assert property (@(posedge clk) disable iff (rst)
    (act_first[0] && $stable(act_first) && $stable(act_topo)) |-> (stage_rail[0] == $past(ext_in[0]))); // R9
endmodule

// File: tb/lutring_xbar_test.sv
module lutring_xbar_test;
  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_we = 1'b0;
  logic [1:0]       cfg_topo = 2'b00;
  logic [7:0]       cfg_first = 8'h00;
  logic [3:0][7:0]  ext_in;
  logic [3:0][7:0]  ext_out;
  logic [7:0][7:0]  stage_dout;
  logic [7:0][7:0]  stage_rail;
  logic             cfg_err;

  int n_chk = 0;
  int n_bad = 0;

  localparam int P8 [8] = '{7, 0, 1, 2, 3, 4, 5, 6};
  localparam int P4 [8] = '{7, 0, 5, 2, 3, 4, 1, 6};
  localparam int P2 [8] = '{7, 6, 5, 4, 3, 2, 1, 0};
  localparam int G4 [8] = '{0, 0, 1, 1, 1, 1, 0, 0};
  localparam int G2 [8] = '{0, 1, 2, 3, 3, 2, 1, 0};

  // {topo, first mask, expect error}
  localparam int NV = 9;
  localparam logic [10:0] VEC [NV] = '{
    {2'b00, 8'h04, 1'b0},
    {2'b01, 8'h12, 1'b0},
    {2'b10, 8'hAA, 1'b0},
    {2'b11, 8'h01, 1'b1},
    {2'b00, 8'h03, 1'b1},
    {2'b01, 8'h03, 1'b1},
    {2'b10, 8'h0F, 1'b0},
    {2'b00, 8'h00, 1'b1},
    {2'b01, 8'h44, 1'b0}
  };

  logic [1:0] m_topo = 2'b00;
  logic [7:0] m_first = 8'h01;

  lutring_xbar uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_topo(cfg_topo), .cfg_first(cfg_first),
    .ext_in(ext_in), .ext_out(ext_out), .stage_dout(stage_dout),
    .stage_rail(stage_rail), .cfg_err(cfg_err)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int m_src(int s);
    case (m_topo)
      2'b01:   return P4[s];
      2'b10:   return P2[s];
      default: return P8[s];
    endcase
  endfunction

  function automatic int m_grp(int s);
    case (m_topo)
      2'b01:   return G4[s];
      2'b10:   return G2[s];
      default: return 0;
    endcase
  endfunction

  function automatic int m_nloop();
    case (m_topo)
      2'b01:   return 2;
      2'b10:   return 4;
      default: return 1;
    endcase
  endfunction

  // rails are combinational from config and inputs
  task automatic check_rails(input string tag);
    for (int s = 0; s < 8; s++) begin
      if (m_first[s]) chk({tag, " head rail R5"}, 32'(stage_rail[s]), 32'(ext_in[m_grp(s)]));
      else            chk({tag, " rail"}, 32'(stage_rail[s]), 32'(stage_dout[m_src(s)]));
    end
  endtask

  // call one edge after the config took effect
  task automatic check_outs(input string tag);
    logic [3:0][7:0] e;
    e = '0;
    for (int s = 0; s < 8; s++)
      if (m_first[s] && m_grp(s) < m_nloop()) e[m_grp(s)] = stage_dout[m_src(s)];
    for (int g = 0; g < 4; g++) chk({tag, " ext_out R6"}, 32'(ext_out[g]), 32'(e[g]));
  endtask

  task automatic write_cfg(input logic [1:0] t, input logic [7:0] f);
    cfg_we = 1'b1; cfg_topo = t; cfg_first = f;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    #4_000_000;
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int s = 0; s < 8; s++) stage_dout[s] = 8'(8'h11 * (s + 1));
    ext_in = '0;
    repeat (3) @(negedge clk);
    chk("R1 err in reset", 32'(cfg_err), 0);
    chk("R1 ext_out in reset", 32'(ext_out), 0);
    rst = 1'b0;
    for (int g = 0; g < 4; g++) ext_in[g] = 8'(8'hA0 + g);
    @(negedge clk);
    chk("R1 err after reset", 32'(cfg_err), 0);
    check_rails("R1 R2 default");
    @(negedge clk);
    check_outs("R1 default");

    for (int v = 0; v < NV; v++) begin
      write_cfg(VEC[v][10:9], VEC[v][8:1]);
      if (!VEC[v][0]) begin m_topo = VEC[v][10:9]; m_first = VEC[v][8:1]; end
      chk($sformatf("R7 R8 err vec%0d", v), 32'(cfg_err), 32'(VEC[v][0]));
      check_rails($sformatf("R2 R3 R4 vec%0d", v));
      @(negedge clk);
      check_outs($sformatf("R7 vec%0d", v));
    end

    // R9: head input registered once
    write_cfg(2'b00, 8'h01);
    m_topo = 2'b00; m_first = 8'h01;
    chk("R8 err cleared", 32'(cfg_err), 0);
    ext_in[0] = 8'h5C;
    #1 chk("R9 rail before edge", 32'(stage_rail[0]), 32'h A0);
    @(negedge clk);
    chk("R9 rail after edge", 32'(stage_rail[0]), 32'h5C);

    // R6: ring result follows stage data one edge later
    stage_dout[7] = 8'h3E;
    #1 chk("R6 out before edge", 32'(ext_out[0]), 32'h88);
    @(negedge clk);
    chk("R6 out after edge", 32'(ext_out[0]), 32'h3E);

    // R7: rejected write keeps routing while flagged
    write_cfg(2'b10, 8'h01);
    chk("R7 err set", 32'(cfg_err), 1);
    repeat (2) @(negedge clk);
    check_rails("R7 held");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule